// File: doc/BRIEF.md
# Windowed Register File Controller

This block keeps a physical file of `NAREG` data registers and presents a sliding view of sixteen of them to the execution pipeline. A window base counts in groups of four physical registers. A window-start mask holds one bit per group and marks the groups that begin a live call frame. Logical register `i` always refers to physical register `(4*base + i) mod NAREG`. Two read ports and one write port work in the logical name space.

On a command strobe the block carries out one windowed operation: call entry, windowed return, relative rotation, restoring the base from a saved value, a pre-access overflow probe, or a stack-pointer-move check. The status word (overflow-enable, exception-mode, call increment, saved base) comes from the surrounding core. The block reports back through a one-cycle exception strobe with a cause code, the base that was in force and the command PC. A successful return also produces a return-target strobe. Raising `exception-mode` and vectoring to a handler are left to the core.

Top module: `winreg_ctrl`

## Requirements
- R1: After synchronous reset the window base is 0, the window-start mask holds only bit 0, every physical register reads 0, and neither strobe is raised.
- R2: Logical index `i` on any port addresses physical register `(4*wbase + i) mod NAREG`. Reads are combinational. A port write lands at the clock edge and is addressed through the base in force before that edge. When a call entry writes the same physical register in the same cycle, the entry's write wins.
- R3: Entry (`cmd_op`=1), return (2) and overflow probe (4) are legal only with `ps_woe`=1 and `ps_excm`=0. An illegal entry or return raises cause 1 (illegal instruction) and changes no state. An illegal probe does nothing.
- R4: A legal entry with `cmd_s` above 3 raises cause 1. Otherwise the value (logical `s` minus `8*cmd_imm`) is written to logical `4*ps_callinc + s`. The base then advances by `ps_callinc` modulo `NAREG/4`, and the mask bit of the new base is set.
- R5: A legal probe with depth `w = cmd_imm[1:0]` finds the smallest `n` in 1..w whose mask bit at `base+n` is set. With no such `n` nothing changes. On a hit the base moves to `base+n` and an overflow cause is raised.
- R6: The overflow cause is selected from the mask bits at `m+1` and `m+2` (with `m = base+n`). It is 3 (four-register spill) if the bit at `m+1` is set, otherwise 4 (eight-register spill) if the bit at `m+2` is set, otherwise 5 (twelve-register spill).
- R7: A return takes `n` from bits 31:30 of logical register 0. Let `m` be the first `k` in 1, 2, 3 whose mask bit at `base-k` is set, or 0 if none is set. The return raises cause 1 if `n` is 0, or if `m` is nonzero and differs from `n`.
- R8: A legal return pulses `ret_valid`. `ret_pc` is `cmd_pc[31:30]` joined with bits 29:0 of logical register 0.
- R9: A legal return moves the base down by `n`. If the mask bit at the new base is set, the old base's bit is cleared. Otherwise the mask is kept and an underflow cause is raised: 6, 7 or 8 for `n` = 1, 2 or 3.
- R10: A stack-pointer-move check (`cmd_op`=5) raises cause 2 (alloca) when the mask bits at `base-1`, `base-2` and `base-3` are all clear. It never changes the base or the mask.
- R11: A rotate (`cmd_op`=3) adds `cmd_imm[3:0]` as a two's-complement value to the base, modulo `NAREG/4`. A restore (`cmd_op`=6) loads the base from `ps_owb`. Codes 0 and 7 do nothing.
- R12: An exception is seen one cycle after its command. It is a single `exc_valid` pulse that carries the cause, the base before the command in `exc_base`, and `cmd_pc` in `exc_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable, logical write port |
| wr_idx | input | 4 | Logical index, write port |
| wr_data | input | 32 | Write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R3, R10, R11) |
| cmd_s | input | 4 | Entry register index |
| cmd_imm | input | 12 | Entry frame size / probe depth / rotate amount |
| cmd_pc | input | 32 | PC of the issuing instruction |
| ps_woe | input | 1 | Window-overflow enable |
| ps_excm | input | 1 | Exception mode |
| ps_callinc | input | 2 | Call increment |
| ps_owb | input | GW | Saved base for restore |
| wbase | output | GW | Current window base |
| wstart | output | NAREG/4 | Window-start mask |
| exc_valid | output | 1 | Exception strobe |
| exc_code | output | 4 | Exception cause |
| exc_base | output | GW | Base before the faulting command |
| exc_pc | output | 32 | PC of the faulting command |
| ret_valid | output | 1 | Return-target strobe |
| ret_pc | output | 32 | Return target |

## Verification
If the base goes wrong, every logical read after that edge lands on a different physical register. Both read ports show this in the very next cycle, and so does the `wbase` output. If the mask goes wrong, it appears on `wstart` at once. It also turns the next probe, return or alloca check into the wrong cause or a missing cause, which is seen one cycle after that command. The reference model is a plain integer model of the physical file, base and mask. It is compared every cycle against the base, the mask, both strobes with their payloads, and randomly chosen logical reads, so a fault is caught within one cycle of becoming visible.

// File: rtl/winreg_pkg.sv
`timescale 1ns/1ps
// Shared command and cause encodings for the windowed register file controller.
package winreg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_ENTRY   = 3'd1,
        CMD_RETW    = 3'd2,
        CMD_ROTW    = 3'd3,
        CMD_WCHECK  = 3'd4,
        CMD_MOVSP   = 3'd5,
        CMD_RESTORE = 3'd6,
        CMD_RSVD    = 3'd7
    } win_cmd_e;

    typedef enum logic [3:0] {
        CAUSE_NONE    = 4'd0,
        CAUSE_ILLEGAL = 4'd1,
        CAUSE_ALLOCA  = 4'd2,
        CAUSE_SPILL4  = 4'd3,
        CAUSE_SPILL8  = 4'd4,
        CAUSE_SPILL12 = 4'd5,
        CAUSE_FILL4   = 4'd6,
        CAUSE_FILL8   = 4'd7,
        CAUSE_FILL12  = 4'd8
    } win_cause_e;

endpackage

// File: rtl/winreg_regfile.sv
`timescale 1ns/1ps
// Physical register array addressed through the window base.
// Assumes NAREG is a power of two and at least 16, so that a logical index
// plus four times the base, truncated to the address width, is the modulo map.
// Write port A (call entry) has priority over write port B (logical port).
module winreg_regfile #(
    parameter int NAREG = 64,
    parameter int DW    = 32,
    parameter int NRD   = 4,
    localparam int GW   = $clog2(NAREG / 4),
    localparam int AW   = GW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] base,
    input  logic [3:0]    rd_idx  [NRD],
    output logic [DW-1:0] rd_data [NRD],
    input  logic          wa_en,
    input  logic [3:0]    wa_idx,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [3:0]    wb_idx,
    input  logic [DW-1:0] wb_data
);

    logic [DW-1:0] mem [NAREG];
    logic [AW-1:0] wa_p;
    logic [AW-1:0] wb_p;

    // logical-to-physical mapping, wraps by truncation
    function automatic logic [AW-1:0] to_phys(input logic [GW-1:0] b, input logic [3:0] idx);
        return {b, 2'b00} + AW'(idx);
    endfunction

    assign wa_p = to_phys(base, wa_idx);
    assign wb_p = to_phys(base, wb_idx);

    // read ports resolved through the current base
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = mem[to_phys(base, rd_idx[r])];
    end

    // clear on reset, then apply the two write ports with A taking priority
    always_ff @(posedge clk) begin
        for (int i = 0; i < NAREG; i++) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (wa_en && wa_p == AW'(i)) begin
                mem[i] <= wa_data;
            end else if (wb_en && wb_p == AW'(i)) begin
                mem[i] <= wb_data;
            end
        end
    end

    assert_entry_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wa_en |=> mem[$past(wa_p)] == $past(wa_data));

    assert_port_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !(wa_en && wa_p == wb_p)) |=> mem[$past(wb_p)] == $past(wb_data));

endmodule

// File: rtl/winreg_scan.sv
`timescale 1ns/1ps
// Combinational window-start mask scanner.
// Looks up to five groups ahead of the base and three behind it, modulo the
// group count, and derives the overflow hit distance, the spill size and the
// distance to the caller's frame. Assumes the group count is a power of two.
module winreg_scan
    import winreg_pkg::*;
#(
    parameter int NG = 16,
    localparam int GW = $clog2(NG)
) (
    input  logic [NG-1:0] wstart,
    input  logic [GW-1:0] base,
    input  logic [1:0]    depth,
    output logic          fwd_hit,
    output logic [1:0]    fwd_n,
    output logic [3:0]    spill_code,
    output logic [1:0]    bwd_m,
    output logic [3:1]    behind
);

    logic [5:1] ahead;
    logic       near_set;
    logic       far_set;

    for (genvar k = 1; k <= 5; k++) begin : g_ahead
        assign ahead[k] = wstart[base + GW'(k)];
    end

    for (genvar k = 1; k <= 3; k++) begin : g_behind
        assign behind[k] = wstart[base - GW'(k)];
    end

    // nearest set group ahead of the base within the probe depth
    always_comb begin
        fwd_hit = 1'b0;
        fwd_n   = 2'd0;
        if (depth >= 2'd1 && ahead[1]) begin
            fwd_hit = 1'b1;
            fwd_n   = 2'd1;
        end else if (depth >= 2'd2 && ahead[2]) begin
            fwd_hit = 1'b1;
            fwd_n   = 2'd2;
        end else if (depth == 2'd3 && ahead[3]) begin
            fwd_hit = 1'b1;
            fwd_n   = 2'd3;
        end
    end

    // spill size from the two groups after the hit
    always_comb begin
        case (fwd_n)
            2'd2:    {near_set, far_set} = {ahead[3], ahead[4]};
            2'd3:    {near_set, far_set} = {ahead[4], ahead[5]};
            default: {near_set, far_set} = {ahead[2], ahead[3]};
        endcase
        if (near_set)     spill_code = CAUSE_SPILL4;
        else if (far_set) spill_code = CAUSE_SPILL8;
        else              spill_code = CAUSE_SPILL12;
    end

    // nearest set group behind the base
    always_comb begin
        if (behind[1])      bwd_m = 2'd1;
        else if (behind[2]) bwd_m = 2'd2;
        else if (behind[3]) bwd_m = 2'd3;
        else                bwd_m = 2'd0;
    end

endmodule

// File: rtl/winreg_ctrl.sv
`timescale 1ns/1ps
// Windowed register file controller (top).
// Holds the window base and window-start mask, executes one windowed command
// per strobe, and registers exception and return-target reports for one
// cycle. The status word is owned by the surrounding core and read here as
// inputs. Assumes NAREG is a power of two, at least 16.
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int NAREG = 64,
    parameter int DW    = 32,
    parameter int IMMW  = 12,
    localparam int NG   = NAREG / 4,
    localparam int GW   = $clog2(NG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      rd_a_idx,
    output logic [DW-1:0]   rd_a_data,
    input  logic [3:0]      rd_b_idx,
    output logic [DW-1:0]   rd_b_data,
    input  logic            wr_en,
    input  logic [3:0]      wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [3:0]      cmd_s,
    input  logic [IMMW-1:0] cmd_imm,
    input  logic [DW-1:0]   cmd_pc,
    input  logic            ps_woe,
    input  logic            ps_excm,
    input  logic [1:0]      ps_callinc,
    input  logic [GW-1:0]   ps_owb,
    output logic [GW-1:0]   wbase,
    output logic [NG-1:0]   wstart,
    output logic            exc_valid,
    output logic [3:0]      exc_code,
    output logic [GW-1:0]   exc_base,
    output logic [DW-1:0]   exc_pc,
    output logic            ret_valid,
    output logic [DW-1:0]   ret_pc
);

    localparam int NRD = 4;

    win_cmd_e      op;
    logic          legal;
    logic [GW-1:0] base_q, base_d;
    logic [NG-1:0] ws_q, ws_d;
    win_cause_e    cause_d, cause_q;
    logic          exc_v_q;
    logic [GW-1:0] exc_base_q;
    logic [DW-1:0] exc_pc_q;
    logic          ret_v_d, ret_v_q;
    logic [DW-1:0] ret_pc_d, ret_pc_q;
    logic          ent_we;
    logic [3:0]    ent_idx;
    logic [DW-1:0] ent_data;
    logic [1:0]    ret_n;
    logic [GW-1:0] rot_step;

    logic [3:0]    rf_idx  [NRD];
    logic [DW-1:0] rf_data [NRD];
    logic [DW-1:0] src_val;
    logic [DW-1:0] reg0_val;

    logic          fwd_hit;
    logic [1:0]    fwd_n;
    logic [3:0]    spill_code;
    logic [1:0]    bwd_m;
    logic [3:1]    behind;

    // port 0/1 serve the pipeline, port 2 the entry source, port 3 logical 0
    assign rf_idx[0] = rd_a_idx;
    assign rf_idx[1] = rd_b_idx;
    assign rf_idx[2] = cmd_s;
    assign rf_idx[3] = 4'd0;
    assign rd_a_data = rf_data[0];
    assign rd_b_data = rf_data[1];
    assign src_val   = rf_data[2];
    assign reg0_val  = rf_data[3];

    winreg_regfile #(.NAREG(NAREG), .DW(DW), .NRD(NRD)) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (base_q),
        .rd_idx  (rf_idx),
        .rd_data (rf_data),
        .wa_en   (ent_we),
        .wa_idx  (ent_idx),
        .wa_data (ent_data),
        .wb_en   (wr_en),
        .wb_idx  (wr_idx),
        .wb_data (wr_data)
    );

    winreg_scan #(.NG(NG)) u_scan (
        .wstart     (ws_q),
        .base       (base_q),
        .depth      (cmd_imm[1:0]),
        .fwd_hit    (fwd_hit),
        .fwd_n      (fwd_n),
        .spill_code (spill_code),
        .bwd_m      (bwd_m),
        .behind     (behind)
    );

    assign op       = win_cmd_e'(cmd_op);
    assign legal    = ps_woe && !ps_excm;
    assign ret_n    = reg0_val[DW-1 -: 2];
    assign rot_step = GW'({{(GW + 4){cmd_imm[3]}}, cmd_imm[3:0]});

    // next window state, entry write and reports for the current command
    always_comb begin
        base_d   = base_q;
        ws_d     = ws_q;
        cause_d  = CAUSE_NONE;
        ret_v_d  = 1'b0;
        ret_pc_d = ret_pc_q;
        ent_we   = 1'b0;
        ent_idx  = {ps_callinc, cmd_s[1:0]};
        ent_data = src_val - (DW'(cmd_imm) << 3);
        if (cmd_valid) begin
            case (op)
                CMD_ENTRY: begin
                    if (!legal || cmd_s[3:2] != 2'b00) begin
                        cause_d = CAUSE_ILLEGAL;
                    end else begin
                        ent_we = 1'b1;
                        base_d = base_q + GW'(ps_callinc);
                        ws_d   = ws_q | (NG'(1) << base_d);
                    end
                end
                CMD_WCHECK: begin
                    if (legal && fwd_hit) begin
                        base_d  = base_q + GW'(fwd_n);
                        cause_d = win_cause_e'(spill_code);
                    end
                end
                CMD_RETW: begin
                    if (!legal || ret_n == 2'd0 || (bwd_m != 2'd0 && bwd_m != ret_n)) begin
                        cause_d = CAUSE_ILLEGAL;
                    end else begin
                        ret_v_d  = 1'b1;
                        ret_pc_d = {cmd_pc[DW-1 -: 2], reg0_val[DW-3:0]};
                        base_d   = base_q - GW'(ret_n);
                        if (behind[ret_n]) begin
                            ws_d = ws_q & ~(NG'(1) << base_q);
                        end else begin
                            case (ret_n)
                                2'd1:    cause_d = CAUSE_FILL4;
                                2'd2:    cause_d = CAUSE_FILL8;
                                default: cause_d = CAUSE_FILL12;
                            endcase
                        end
                    end
                end
                CMD_ROTW: begin
                    base_d = base_q + rot_step;
                end
                CMD_MOVSP: begin
                    if (behind == 3'b000) cause_d = CAUSE_ALLOCA;
                end
                CMD_RESTORE: begin
                    base_d = ps_owb;
                end
                default: ;
            endcase
        end
    end

    // window state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ws_q   <= NG'(1);
        end else begin
            base_q <= base_d;
            ws_q   <= ws_d;
        end
    end

    // one-cycle exception and return-target reports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_v_q    <= 1'b0;
            cause_q    <= CAUSE_NONE;
            exc_base_q <= '0;
            exc_pc_q   <= '0;
            ret_v_q    <= 1'b0;
            ret_pc_q   <= '0;
        end else begin
            exc_v_q  <= (cause_d != CAUSE_NONE);
            cause_q  <= cause_d;
            ret_v_q  <= ret_v_d;
            ret_pc_q <= ret_pc_d;
            if (cause_d != CAUSE_NONE) begin
                exc_base_q <= base_q;
                exc_pc_q   <= cmd_pc;
            end
        end
    end

    assign wbase     = base_q;
    assign wstart    = ws_q;
    assign exc_valid = exc_v_q;
    assign exc_code  = cause_q;
    assign exc_base  = exc_base_q;
    assign exc_pc    = exc_pc_q;
    assign ret_valid = ret_v_q;
    assign ret_pc    = ret_pc_q;

    assert_exc_follows_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(cmd_valid));

    assert_bad_mode_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == CMD_RETW && !legal) |=> (exc_valid && exc_code == CAUSE_ILLEGAL));

    assert_bad_mode_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == CMD_WCHECK && !legal) |=> (!exc_valid && $stable(wbase) && $stable(wstart)));

    assert_entry_marks_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == CMD_ENTRY && legal && cmd_s < 4'd4) |=> wstart[wbase]);

    assert_movsp_static_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == CMD_MOVSP) |=> ($stable(wbase) && $stable(wstart)));

    assert_return_not_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> !(exc_valid && exc_code == CAUSE_ILLEGAL));

    assert_spill_only_on_probe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_code >= CAUSE_SPILL4 && exc_code <= CAUSE_SPILL12)
            |-> $past(op == CMD_WCHECK));

endmodule

// File: tb/winreg_ctrl_bench.sv
`timescale 1ns/1ps
module winreg_ctrl_bench;

    localparam int NAREG = 64;
    localparam int DW    = 32;
    localparam int NG    = NAREG / 4;
    localparam int GW    = $clog2(NG);

    logic            clk = 1'b0;
    logic            rst_n;
    logic [3:0]      rd_a_idx, rd_b_idx, wr_idx, cmd_s;
    logic [DW-1:0]   rd_a_data, rd_b_data, wr_data, cmd_pc, exc_pc, ret_pc;
    logic            wr_en, cmd_valid, ps_woe, ps_excm, exc_valid, ret_valid;
    logic [2:0]      cmd_op;
    logic [11:0]     cmd_imm;
    logic [1:0]      ps_callinc;
    logic [GW-1:0]   ps_owb, wbase, exc_base;
    logic [NG-1:0]   wstart;
    logic [3:0]      exc_code;

    always #2.5 clk = ~clk;

    winreg_ctrl #(.NAREG(NAREG), .DW(DW)) u_winreg_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_s(cmd_s),
        .cmd_imm(cmd_imm), .cmd_pc(cmd_pc),
        .ps_woe(ps_woe), .ps_excm(ps_excm), .ps_callinc(ps_callinc), .ps_owb(ps_owb),
        .wbase(wbase), .wstart(wstart),
        .exc_valid(exc_valid), .exc_code(exc_code), .exc_base(exc_base), .exc_pc(exc_pc),
        .ret_valid(ret_valid), .ret_pc(ret_pc)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // reference state
    logic [DW-1:0] mref [NAREG];
    int            mbase;
    logic [NG-1:0] mws;
    bit            e_exc, e_ret;
    int            e_code, e_base;
    logic [DW-1:0] e_pc, e_rpc;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int lp(int i);
        return (mbase * 4 + i) % NAREG;
    endfunction

    // advance the model by one edge using the inputs now applied
    task automatic model_step();
        bit            legal = ps_woe && !ps_excm;
        logic [DW-1:0] src = mref[lp(int'(cmd_s))];
        logic [DW-1:0] l0  = mref[lp(0)];
        int            nb  = mbase;
        logic [NG-1:0] nws = mws;
        int            code = 0;
        e_ret  = 0;
        e_base = mbase;
        e_pc   = cmd_pc;
        if (wr_en) mref[lp(int'(wr_idx))] = wr_data;
        if (cmd_valid) begin
            case (int'(cmd_op))
                1: begin
                    if (!legal || cmd_s > 3) code = 1;
                    else begin
                        mref[(mbase * 4 + int'(ps_callinc) * 4 + int'(cmd_s)) % NAREG] = src - 32'(cmd_imm) * 8;
                        nb = (mbase + int'(ps_callinc)) % NG;
                        nws[nb] = 1'b1;
                    end
                end
                4: begin
                    if (legal) begin
                        int hit = 0;
                        for (int n = 1; n <= int'(cmd_imm[1:0]); n++)
                            if (hit == 0 && mws[(mbase + n) % NG]) hit = n;
                        if (hit != 0) begin
                            int m = (mbase + hit) % NG;
                            nb = m;
                            if (mws[(m + 1) % NG])      code = 3;
                            else if (mws[(m + 2) % NG]) code = 4;
                            else                        code = 5;
                        end
                    end
                end
                2: begin
                    int n = int'(l0[31:30]);
                    int m = 0;
                    for (int k = 1; k <= 3; k++)
                        if (m == 0 && mws[(mbase - k + NG) % NG]) m = k;
                    if (!legal || n == 0 || (m != 0 && m != n)) code = 1;
                    else begin
                        e_ret = 1;
                        e_rpc = {cmd_pc[31:30], l0[29:0]};
                        nb = (mbase - n + NG) % NG;
                        if (mws[nb]) nws[mbase] = 1'b0;
                        else         code = 5 + n;
                    end
                end
                3: begin
                    int d = int'(cmd_imm[3:0]);
                    if (d >= 8) d -= 16;
                    nb = ((mbase + d) % NG + NG) % NG;
                end
                5: begin
                    if (!mws[(mbase + NG - 1) % NG] && !mws[(mbase + NG - 2) % NG] &&
                        !mws[(mbase + NG - 3) % NG]) code = 2;
                end
                6: nb = int'(ps_owb);
                default: ;
            endcase
        end
        e_exc  = (code != 0);
        e_code = code;
        mbase  = nb;
        mws    = nws;
    endtask

    // one clock: model, edge, compare at the following falling edge
    task automatic tick(string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(req, "wbase", 64'(wbase), 64'(mbase));
        chk(req, "wstart", 64'(wstart), 64'(mws));
        chk(req, "exc_valid", 64'(exc_valid), 64'(e_exc));
        if (e_exc) begin
            chk(req, "exc_code", 64'(exc_code), 64'(e_code));
            chk("R12", "exc_base", 64'(exc_base), 64'(e_base));
            chk("R12", "exc_pc", 64'(exc_pc), 64'(e_pc));
        end
        chk(req, "ret_valid", 64'(ret_valid), 64'(e_ret));
        if (e_ret) chk("R8", "ret_pc", 64'(ret_pc), 64'(e_rpc));
        cmd_valid = 0;
        wr_en     = 0;
        rd_a_idx  = 4'($urandom_range(15));
        rd_b_idx  = 4'($urandom_range(15));
        #0.5;
        chk("R2", "rd_a_data", 64'(rd_a_data), 64'(mref[lp(int'(rd_a_idx))]));
        chk("R2", "rd_b_data", 64'(rd_b_data), 64'(mref[lp(int'(rd_b_idx))]));
    endtask

    task automatic do_cmd(string req, int op, int s, int imm, logic [DW-1:0] pc);
        cmd_valid = 1; cmd_op = 3'(op); cmd_s = 4'(s); cmd_imm = 12'(imm); cmd_pc = pc;
        tick(req);
    endtask

    task automatic do_wr(string req, int idx, logic [DW-1:0] d);
        wr_en = 1; wr_idx = 4'(idx); wr_data = d;
        tick(req);
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i);
            rd_b_idx = 4'(15 - i);
            #0.1;
            chk(req, "sweep_a", 64'(rd_a_data), 64'(mref[lp(i)]));
            chk(req, "sweep_b", 64'(rd_b_data), 64'(mref[lp(15 - i)]));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished run");
        finish_run();
    end

    initial begin
        string tags [8] = '{"R11", "R4", "R7", "R11", "R5", "R10", "R11", "R11"};
        rst_n = 0; wr_en = 0; cmd_valid = 0; cmd_op = 0; cmd_s = 0; cmd_imm = 0; cmd_pc = 0;
        wr_idx = 0; wr_data = 0; rd_a_idx = 0; rd_b_idx = 0;
        ps_woe = 1; ps_excm = 0; ps_callinc = 0; ps_owb = 0;
        for (int i = 0; i < NAREG; i++) mref[i] = '0;
        mbase = 0; mws = NG'(1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #0.5;
        // R1: reset state
        chk("R1", "wbase", 64'(wbase), 64'd0);
        chk("R1", "wstart", 64'(wstart), 64'd1);
        chk("R1", "exc_valid", 64'(exc_valid), 64'd0);
        chk("R1", "ret_valid", 64'(ret_valid), 64'd0);
        check_all("R1");
        @(negedge clk);

        // R2: logical writes and reads through base 0
        for (int i = 0; i < 16; i++) do_wr("R2", i, 32'h1000_0000 + 32'(i) * 32'h11);
        check_all("R2");
        @(negedge clk);

        // R11: rotations with wrap, reserved code, restore
        do_cmd("R11", 3, 0, 3, 32'h100);
        do_cmd("R11", 3, 0, 12, 32'h104);
        do_cmd("R11", 3, 0, 7, 32'h108);
        do_cmd("R11", 7, 0, 5, 32'h10c);
        ps_owb = 4'd2;
        do_cmd("R11", 6, 0, 0, 32'h110);
        check_all("R2");
        @(negedge clk);

        // R2: entry and port write to the same physical register; entry wins
        ps_callinc = 1;
        wr_en = 1; wr_idx = 4'd5; wr_data = 32'hDEAD_BEEF;
        do_cmd("R2", 1, 1, 2, 32'h114);
        do_cmd("R11", 6, 0, 0, 32'h118);

        // R3: bad mode for entry, return and probe
        ps_woe = 0;
        do_cmd("R3", 1, 1, 0, 32'h200);
        do_cmd("R3", 2, 0, 0, 32'h204);
        ps_woe = 1; ps_excm = 1;
        do_cmd("R3", 4, 0, 3, 32'h208);
        do_cmd("R3", 1, 0, 0, 32'h20c);
        ps_excm = 0;

        // R4: out-of-range s, then entries with each call increment
        do_cmd("R4", 1, 7, 0, 32'h300);
        for (int c = 1; c <= 3; c++) begin
            ps_callinc = 2'(c);
            do_cmd("R4", 1, 1, 5 + c, 32'h304 + 32'(c));
            check_all("R4");
            @(negedge clk);
        end

        // R5/R6: probes with misses and each spill size
        do_cmd("R5", 4, 0, 3, 32'h400);
        do_cmd("R5", 4, 0, 0, 32'h404);
        do_cmd("R11", 3, 0, 13, 32'h408);
        do_cmd("R6", 4, 0, 3, 32'h40c);
        do_cmd("R11", 3, 0, 9, 32'h410);
        do_cmd("R5", 4, 0, 1, 32'h414);
        do_cmd("R6", 4, 0, 2, 32'h418);
        ps_callinc = 1;
        do_cmd("R4", 1, 0, 0, 32'h41c);
        do_cmd("R11", 3, 0, 14, 32'h420);
        do_cmd("R6", 4, 0, 1, 32'h424);

        // R7/R8/R9: return with n = 0, mismatched n, and legal returns
        do_wr("R7", 0, 32'h0000_0040);
        do_cmd("R7", 2, 0, 0, 32'h500);
        for (int n = 1; n <= 3; n++) begin
            do_wr("R7", 0, {2'(n), 30'h0123_4560 + 30'(n)});
            do_cmd("R9", 2, 0, 0, 32'hC000_0600 + 32'(n));
        end
        ps_callinc = 2;
        do_cmd("R4", 1, 2, 1, 32'h610);
        do_wr("R8", 0, 32'h8000_3210);
        do_cmd("R8", 2, 0, 0, 32'h4000_0614);

        // R10: stack-pointer-move checks at several bases
        for (int k = 0; k < 6; k++) begin
            do_cmd("R10", 5, 0, 0, 32'h700 + 32'(k));
            do_cmd("R11", 3, 0, 3, 32'h720 + 32'(k));
        end

        // mixed random traffic
        for (int t = 0; t < 4000; t++) begin
            int op = $urandom_range(7);
            ps_woe     = ($urandom_range(9) != 0);
            ps_excm    = ($urandom_range(9) == 0);
            ps_callinc = 2'($urandom_range(3));
            ps_owb     = GW'($urandom_range(NG - 1));
            if ($urandom_range(2) == 0) begin
                wr_en = 1; wr_idx = 4'($urandom_range(15)); wr_data = $urandom;
                if ($urandom_range(3) == 0) wr_data[31:30] = 2'($urandom_range(3));
            end
            if ($urandom_range(4) == 0) begin
                tick("R2");
            end else begin
                do_cmd(tags[op], op, (op == 1 && $urandom_range(5) == 0) ? 9 : $urandom_range(3),
                       $urandom_range(4095), $urandom);
            end
        end
        check_all("R2");
        finish_run();
    end

endmodule